// File: doc/BRIEF.md
# SPI Flash Memory-Mapped Access Sequencer

This block sits between a simple memory-mapped request/response bus and a byte-wide SPI shifter for one flash chip select. Each accepted request of one to four bytes becomes a complete flash transaction. The block pulls chip select low and sends the configured opcode. It then sends the address, highest byte first, and in fast-read mode a run of dummy bytes. After that it moves the data bytes and releases chip select. A read returns the bytes it collected, packed little-endian. A write sends the request data lowest byte first.

Before the address is sent, it is folded into the chip-select window given by a base and a size mask. A request can therefore never reach flash outside that window. The block checks the access size and the direction against the configured mode. A request that fails either check is refused at once with an error response, and the SPI side sees nothing. Configuration is captured when a request is accepted. It can change between transactions but not during one.

Top module: `sfm_seq`

## Requirements
- R1: After reset, and whenever reset is applied in the middle of a transaction, chip select (`spi_cs_n`) is high, `byte_req` and `rsp_valid` are low, and `req_ready` is high once reset is released.
- R2: With `cfg_addr4` = 0, a transaction sends `cfg_cmd` first and then three address bytes, bits [23:16], then [15:8], then [7:0].
- R3: With `cfg_addr4` = 1, four address bytes are sent, starting with bits [31:24].
- R4: When `cfg_mode` = 1 (fast read), ({`cfg_dummy_hi`,`cfg_dummy_lo`}) × 8 dummy bytes, each 0xFF, follow the address and come before the data.
- R5: When `cfg_mode` = 0 (read) or 2 (write), no dummy byte is sent, whatever the dummy fields hold.
- R6: For a read of N bytes, the k-th received data byte (k = 0..N-1) lands in `rsp_rdata[8k+7:8k]`, and the bits above byte N-1 are zero.
- R7: For a write of N bytes, the data bytes sent are `req_wdata[7:0]` first, up to byte N-1.
- R8: The address sent is (`cfg_seg_base` & ~`cfg_seg_mask`) | (`req_addr` & `cfg_seg_mask`).
- R9: `spi_cs_n` rises and `rsp_valid` is high, with `rsp_err` = 0, in the cycle after the cycle in which the last data byte is acknowledged. `rsp_valid` lasts one cycle, and `req_ready` is low while chip select is low.
- R10: A request with `req_size` of 0 or greater than 4 gets `rsp_valid` with `rsp_err` = 1 in the cycle after acceptance. Chip select stays high and no byte is requested.
- R11: A request with `cfg_mode` = 3, a write when the mode is not 2, or a read when the mode is 2 is refused the same way as in R10.
- R12: While `byte_req` is high and `byte_ack` is low, `byte_req` stays high and `byte_out` holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_size | input | SZW | Bytes to move (1 to 4 valid) |
| req_wdata | input | DW | Write data, byte 0 in bits [7:0] |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request refused |
| rsp_rdata | output | DW | Read data, little-endian |
| cfg_mode | input | 2 | 0 read, 1 fast read, 2 write, 3 reserved |
| cfg_cmd | input | 8 | Opcode byte |
| cfg_dummy_lo | input | DLO_W | Low dummy-count field |
| cfg_dummy_hi | input | DHI_W | High dummy-count field |
| cfg_addr4 | input | 1 | Four-byte addressing enable |
| cfg_seg_base | input | AW | Window base |
| cfg_seg_mask | input | AW | Window offset mask (size − 1) |
| spi_cs_n | output | 1 | Chip select, active low |
| byte_req | output | 1 | Byte transfer requested from the shifter |
| byte_out | output | 8 | Byte to shift out |
| byte_ack | input | 1 | Shifter finished the current byte |
| byte_in | input | 8 | Byte shifted in, valid with `byte_ack` |

## Verification
The assertions take three things for granted. The shifter raises `byte_ack` only while `byte_req` is high, and for one cycle per byte. The window inputs stay steady for at least one cycle after a request is accepted. The configuration stays steady for the whole transaction. The bench's shifter model waits a fixed delay, pulses the acknowledge once, and then waits for the next request. The bench changes configuration only on the falling edge just before a request, while the block is idle. Refused requests are issued only when the block is idle, so the one-cycle response pulse is never overlapped.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4
  } phase_e;

  localparam logic [1:0] MODE_READ  = 2'd0;
  localparam logic [1:0] MODE_FAST  = 2'd1;
  localparam logic [1:0] MODE_WRITE = 2'd2;
  localparam logic [1:0] MODE_RSVD  = 2'd3;

  localparam logic [7:0] DUMMY_FILL = 8'hFF;

endpackage

// File: rtl/sfm_seg_fold.sv
module sfm_seg_fold #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_in,
  input  logic [AW-1:0] seg_base,
  input  logic [AW-1:0] seg_mask,
  output logic [AW-1:0] addr_out
);

  function automatic logic [AW-1:0] fold(input logic [AW-1:0] a,
                                         input logic [AW-1:0] base,
                                         input logic [AW-1:0] mask);
    return (base & ~mask) | (a & mask);
  endfunction

  assign addr_out = fold(addr_in, seg_base, seg_mask);

endmodule

// File: rtl/sfm_byte_pick.sv
module sfm_byte_pick
  import sfm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  phase_e        phase,
  input  logic [CW-1:0] idx,
  input  logic [7:0]    cmd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [7:0]    byte_sel
);

  function automatic logic [7:0] lane_of(input logic [AW-1:0] v, input logic [CW-1:0] k);
    return 8'(v >> (8 * k));
  endfunction

  function automatic logic [7:0] wlane_of(input logic [DW-1:0] v, input logic [CW-1:0] k);
    return 8'(v >> (8 * k));
  endfunction

  always_comb begin
    case (phase)
      PH_CMD:   byte_sel = cmd;
      PH_ADDR:  byte_sel = lane_of(addr, idx);
      PH_DUMMY: byte_sel = DUMMY_FILL;
      PH_DATA:  byte_sel = wlane_of(wdata, idx);
      default:  byte_sel = 8'h00;
    endcase
  end

endmodule

// File: rtl/sfm_rx_pack.sv
module sfm_rx_pack #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] lane_idx,
  input  logic [7:0]    lane_byte,
  output logic [DW-1:0] packed_data
);

  localparam int NB = DW / 8;

  for (genvar l = 0; l < NB; l++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                lane_q <= 8'h00;
      else if (clr)                              lane_q <= 8'h00;
      else if (load && lane_idx == CW'(l))       lane_q <= lane_byte;
    end
    assign packed_data[8*l +: 8] = lane_q;
  end

endmodule

// File: rtl/sfm_seq.sv
module sfm_seq
  import sfm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SZW   = 3,
  parameter int DLO_W = 2,
  parameter int DHI_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [SZW-1:0]   req_size,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_rdata,
  input  logic [1:0]       cfg_mode,
  input  logic [7:0]       cfg_cmd,
  input  logic [DLO_W-1:0] cfg_dummy_lo,
  input  logic [DHI_W-1:0] cfg_dummy_hi,
  input  logic             cfg_addr4,
  input  logic [AW-1:0]    cfg_seg_base,
  input  logic [AW-1:0]    cfg_seg_mask,
  output logic             spi_cs_n,
  output logic             byte_req,
  output logic [7:0]       byte_out,
  input  logic             byte_ack,
  input  logic [7:0]       byte_in
);

  localparam int NB        = DW / 8;
  localparam int DSEL_W    = DLO_W + DHI_W;
  localparam int MAX_DUMMY = ((1 << DSEL_W) - 1) * 8;
  localparam int MAX_CNT   = (MAX_DUMMY > NB) ? MAX_DUMMY : NB;
  localparam int CW        = $clog2(MAX_CNT + AW / 8 + 1);

  function automatic logic [CW-1:0] dummy_count(input logic [DHI_W-1:0] hi,
                                                input logic [DLO_W-1:0] lo);
    return CW'({hi, lo}) << 3;
  endfunction

  function automatic logic size_ok(input logic [SZW-1:0] s);
    return (s != '0) && (s <= SZW'(NB));
  endfunction

  function automatic logic dir_ok(input logic [1:0] mode, input logic wr);
    return (mode != MODE_RSVD) && (wr == (mode == MODE_WRITE));
  endfunction

  phase_e          phase;
  logic [CW-1:0]   idx;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [SZW-1:0]  size_q;
  logic            wr_q;
  logic [7:0]      cmd_q;
  logic [CW-1:0]   nadr_q;
  logic [CW-1:0]   ndum_q;
  logic            cs_n_q;
  logic            rsp_v_q;
  logic            rsp_e_q;
  logic [AW-1:0]   eff_addr;

  // named events
  logic req_fire, req_bad, accept_ok, reject_fire, byte_step, in_dummy, last_data;

  assign req_ready   = (phase == PH_IDLE) && !rsp_v_q;
  assign req_fire    = req_valid && req_ready;
  assign req_bad     = !size_ok(req_size) || !dir_ok(cfg_mode, req_write);
  assign accept_ok   = req_fire && !req_bad;
  assign reject_fire = req_fire && req_bad;
  assign byte_req    = (phase != PH_IDLE);
  assign byte_step   = byte_req && byte_ack;
  assign in_dummy    = (phase == PH_DUMMY);
  assign last_data   = (phase == PH_DATA) && (idx == CW'(size_q) - CW'(1));

  sfm_seg_fold #(.AW(AW)) u_fold (
    .addr_in  (req_addr),
    .seg_base (cfg_seg_base),
    .seg_mask (cfg_seg_mask),
    .addr_out (eff_addr)
  );

  sfm_byte_pick #(.AW(AW), .DW(DW), .CW(CW)) u_pick (
    .phase    (phase),
    .idx      (idx),
    .cmd      (cmd_q),
    .addr     (addr_q),
    .wdata    (wdata_q),
    .byte_sel (byte_out)
  );

  sfm_rx_pack #(.DW(DW), .CW(CW)) u_pack (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (accept_ok),
    .load        (byte_step && (phase == PH_DATA) && !wr_q),
    .lane_idx    (idx),
    .lane_byte   (byte_in),
    .packed_data (rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      idx     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      size_q  <= '0;
      wr_q    <= 1'b0;
      cmd_q   <= 8'h00;
      nadr_q  <= '0;
      ndum_q  <= '0;
      cs_n_q  <= 1'b1;
      rsp_v_q <= 1'b0;
      rsp_e_q <= 1'b0;
    end else begin
      rsp_v_q <= 1'b0;
      if (reject_fire) begin
        rsp_v_q <= 1'b1;
        rsp_e_q <= 1'b1;
      end else if (accept_ok) begin
        phase   <= PH_CMD;
        cs_n_q  <= 1'b0;
        rsp_e_q <= 1'b0;
        idx     <= '0;
        addr_q  <= eff_addr;
        wdata_q <= req_wdata;
        size_q  <= req_size;
        wr_q    <= req_write;
        cmd_q   <= cfg_cmd;
        nadr_q  <= cfg_addr4 ? CW'(AW / 8) : CW'(3);
        ndum_q  <= (cfg_mode == MODE_FAST) ? dummy_count(cfg_dummy_hi, cfg_dummy_lo) : '0;
      end else if (byte_step) begin
        case (phase)
          PH_CMD: begin
            phase <= PH_ADDR;
            idx   <= nadr_q - CW'(1);
          end
          PH_ADDR: begin
            if (idx != '0) begin
              idx <= idx - CW'(1);
            end else if (ndum_q != '0) begin
              phase <= PH_DUMMY;
              idx   <= ndum_q - CW'(1);
            end else begin
              phase <= PH_DATA;
              idx   <= '0;
            end
          end
          PH_DUMMY: begin
            if (idx != '0) begin
              idx <= idx - CW'(1);
            end else begin
              phase <= PH_DATA;
              idx   <= '0;
            end
          end
          PH_DATA: begin
            if (last_data) begin
              phase   <= PH_IDLE;
              cs_n_q  <= 1'b1;
              rsp_v_q <= 1'b1;
              idx     <= '0;
            end else begin
              idx <= idx + CW'(1);
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assign spi_cs_n  = cs_n_q;
  assign rsp_valid = rsp_v_q;
  assign rsp_err   = rsp_e_q;

  assert_hold_byte_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && !byte_ack) |=> (byte_req && $stable(byte_out)));

  assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reject_fire |=> (rsp_valid && rsp_err && spi_cs_n && !byte_req));

  assert_rsp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready);

  assert_cs_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (spi_cs_n && !byte_req));

  assert_dummy_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && in_dummy) |-> (byte_out == 8'hFF));

  assert_addr_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ok |=> (((addr_q ^ cfg_seg_base) & ~cfg_seg_mask) == '0));

endmodule

// File: tb/sfm_seq_bench.sv
module sfm_seq_bench;

  typedef struct packed {
    logic        wr;
    logic [1:0]  mode;
    logic        ext;
    logic        dhi;
    logic [1:0]  dlo;
    logic [2:0]  size;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] base;
    logic [31:0] mask;
    logic [7:0]  cmd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 3'd4, 32'h00123456, 32'h0,        32'h0,        32'h00FFFFFF, 8'h03},
    '{1'b0, 2'd1, 1'b0, 1'b0, 2'd1, 3'd2, 32'h00000A0B, 32'h0,        32'h0,        32'hFFFFFFFF, 8'h0B},
    '{1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 3'd1, 32'h01234567, 32'h0,        32'h0,        32'h0FFFFFFF, 8'h13},
    '{1'b1, 2'd2, 1'b0, 1'b0, 2'd3, 3'd3, 32'h00000100, 32'hAABBCCDD, 32'h0,        32'hFFFFFFFF, 8'h02},
    '{1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 3'd4, 32'h0F001234, 32'h0,        32'h02000000, 32'h000FFFFF, 8'h03},
    '{1'b0, 2'd1, 1'b1, 1'b1, 2'd3, 3'd4, 32'h080000FF, 32'h0,        32'h0,        32'hFFFFFFFF, 8'h0C},
    '{1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 3'd0, 32'h00000010, 32'h0,        32'h0,        32'hFFFFFFFF, 8'h03},
    '{1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 3'd5, 32'h00000010, 32'h0,        32'h0,        32'hFFFFFFFF, 8'h03},
    '{1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 3'd2, 32'h00000020, 32'h1234,     32'h0,        32'hFFFFFFFF, 8'h02},
    '{1'b0, 2'd3, 1'b0, 1'b0, 2'd0, 3'd2, 32'h00000030, 32'h0,        32'h0,        32'hFFFFFFFF, 8'h03},
    '{1'b0, 2'd2, 1'b0, 1'b0, 2'd0, 3'd2, 32'h00000040, 32'h0,        32'h0,        32'hFFFFFFFF, 8'h03}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  cfg_mode = '0;
  logic [7:0]  cfg_cmd = '0;
  logic [1:0]  cfg_dummy_lo = '0;
  logic        cfg_dummy_hi = 1'b0;
  logic        cfg_addr4 = 1'b0;
  logic [31:0] cfg_seg_base = '0;
  logic [31:0] cfg_seg_mask = '1;
  logic        byte_ack = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        req_ready, rsp_valid, rsp_err, spi_cs_n, byte_req;
  logic [31:0] rsp_rdata;
  logic [7:0]  byte_out;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sfm_seq u_sfm_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .cfg_mode(cfg_mode), .cfg_cmd(cfg_cmd),
    .cfg_dummy_lo(cfg_dummy_lo), .cfg_dummy_hi(cfg_dummy_hi),
    .cfg_addr4(cfg_addr4), .cfg_seg_base(cfg_seg_base),
    .cfg_seg_mask(cfg_seg_mask), .spi_cs_n(spi_cs_n), .byte_req(byte_req),
    .byte_out(byte_out), .byte_ack(byte_ack), .byte_in(byte_in)
  );

  // shifter model: one idle falling edge, then a one-cycle acknowledge
  logic [7:0] txlog [0:127];
  int  pos = 0;
  int  wcnt = 0;
  int  cs_low_cnt = 0;
  int  last_ack_cyc = 0;
  bit  prev_cs = 1'b1;
  bit  stab_bad = 1'b0;
  logic [7:0] held = '0;

  always @(negedge clk) begin
    if (!spi_cs_n) cs_low_cnt = cs_low_cnt + 1;
    if (prev_cs && !spi_cs_n) begin pos = 0; stab_bad = 1'b0; end
    prev_cs = spi_cs_n;
    if (!rst_n) begin
      byte_ack <= 1'b0;
      wcnt = 0;
    end else if (byte_ack) begin
      byte_ack <= 1'b0;
    end else if (byte_req) begin
      if (wcnt == 0) held = byte_out;
      else if (byte_out != held) stab_bad = 1'b1;
      if (wcnt == 1) begin
        if (pos < 128) txlog[pos] = byte_out;
        byte_in  <= 8'h40 + 8'(pos);
        byte_ack <= 1'b1;
        last_ack_cyc = cyc;
        pos = pos + 1;
        wcnt = 0;
      end else begin
        wcnt = wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    bit size_bad, dir_bad;
    int nA, nD, total, n, cs_before;
    logic [31:0] eff, exp_rd;
    bit ok_a, ok_d, ok_w, busy_bad;
    string atag, dtag;
    size_bad = (v.size == 0) || (v.size > 4);
    dir_bad  = (v.mode == 2'd3) || (v.wr != (v.mode == 2'd2));
    @(negedge clk);
    cfg_mode = v.mode; cfg_cmd = v.cmd; cfg_dummy_lo = v.dlo; cfg_dummy_hi = v.dhi;
    cfg_addr4 = v.ext; cfg_seg_base = v.base; cfg_seg_mask = v.mask;
    req_write = v.wr; req_addr = v.addr; req_size = v.size; req_wdata = v.wdata;
    req_valid = 1'b1;
    cs_before = cs_low_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    if (size_bad || dir_bad) begin
      if (size_bad) begin
        chk(rsp_valid && rsp_err, "R10", {rsp_valid, rsp_err}, 2'b11);
        chk(spi_cs_n && !byte_req && cs_low_cnt == cs_before, "R10", cs_low_cnt - cs_before, 0);
      end else begin
        chk(rsp_valid && rsp_err, "R11", {rsp_valid, rsp_err}, 2'b11);
        chk(spi_cs_n && !byte_req && cs_low_cnt == cs_before, "R11", cs_low_cnt - cs_before, 0);
      end
      @(negedge clk);
      chk(!rsp_valid, "R9", rsp_valid, 0);
      return;
    end
    eff = (v.base & ~v.mask) | (v.addr & v.mask);
    nA  = v.ext ? 4 : 3;
    nD  = (v.mode == 2'd1) ? (int'(v.dhi) * 4 + int'(v.dlo)) * 8 : 0;
    total = 1 + nA + nD + int'(v.size);
    n = 0; busy_bad = 1'b0;
    while (!rsp_valid && n < 2000) begin
      if (!spi_cs_n && req_ready) busy_bad = 1'b1;
      @(negedge clk);
      n++;
    end
    chk(rsp_valid && !rsp_err && spi_cs_n, "R9", {rsp_valid, rsp_err, spi_cs_n}, 3'b101);
    chk(!busy_bad, "R9", busy_bad, 0);
    chk(cyc == last_ack_cyc + 1, "R9", cyc, last_ack_cyc + 1);
    chk(pos == total, "R4", pos, total);
    ok_a = (txlog[0] == v.cmd);
    for (int k = 0; k < nA; k++)
      if (txlog[1 + k] != 8'(eff >> (8 * (nA - 1 - k)))) ok_a = 1'b0;
    if ((v.addr & ~v.mask) != (v.base & ~v.mask)) atag = "R8";
    else atag = v.ext ? "R3" : "R2";
    chk(ok_a, atag, {txlog[0], txlog[1], txlog[2], txlog[3]}, {v.cmd, eff[31:8]});
    ok_d = 1'b1;
    for (int k = 0; k < nD; k++)
      if (txlog[1 + nA + k] != 8'hFF) ok_d = 1'b0;
    dtag = (v.mode == 2'd1) ? "R4" : "R5";
    chk(ok_d && pos == total, dtag, pos, total);
    if (v.wr) begin
      ok_w = 1'b1;
      for (int k = 0; k < int'(v.size); k++)
        if (txlog[1 + nA + nD + k] != 8'(v.wdata >> (8 * k))) ok_w = 1'b0;
      chk(ok_w, "R7", txlog[1 + nA + nD], v.wdata[7:0]);
    end else begin
      exp_rd = '0;
      for (int k = 0; k < int'(v.size); k++)
        exp_rd[8*k +: 8] = 8'h40 + 8'(1 + nA + nD + k);
      chk(rsp_rdata == exp_rd, "R6", rsp_rdata, exp_rd);
    end
    chk(!stab_bad, "R12", stab_bad, 0);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9", {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n && !byte_req && !rsp_valid && req_ready, "R1",
        {spi_cs_n, byte_req, rsp_valid, req_ready}, 4'b1001);
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    // reset in the middle of a long fast read
    @(negedge clk);
    cfg_mode = 2'd1; cfg_addr4 = 1'b1; cfg_dummy_hi = 1'b1; cfg_dummy_lo = 2'd3;
    cfg_seg_base = '0; cfg_seg_mask = '1; cfg_cmd = 8'h0C;
    req_write = 1'b0; req_addr = 32'h40; req_size = 3'd4; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk(!spi_cs_n && !req_ready, "R9", {spi_cs_n, req_ready}, 2'b00);
    rst_n = 1'b0;
    @(negedge clk);
    chk(spi_cs_n && !byte_req && !rsp_valid, "R1", {spi_cs_n, byte_req, rsp_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1", req_ready, 1);
    run_vec(VECS[0]);
    run_vec(VECS[3]);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule